// File: doc/BRIEF.md
# Bunch Crossing Counter with Reset Preset

This block reads one serial command line. Triggers, bunch-count resets and event-count resets all share that line. Every command is three ticks long and begins with a 1. The block keeps a bunch crossing counter, which advances on every clock tick and wraps after a programmable rollover value. A bunch-count reset does not clear this counter to zero. It loads a programmable preset instead. If the preset is a few counts below the orbit length, an upstream timing system can send the reset a fixed number of ticks early, and the count still lines up with the real beam.

An event counter advances once for each decoded trigger. It clears only on an event-count reset. Each decoded trigger produces a one-cycle pulse. The pulse carries the bunch and event numbers that were present on the tick when the trigger code completed. Two further outputs are derived from the live bunch count: a coarse time and a reject count. Each one adds a programmable offset to the bunch count and wraps at the orbit length.

Because the line is busy for three ticks with each reset code, no trigger can land on the first counts after a reset. A negative preset moves that blind window into the previous orbit.

Top module: `bxc_timing_core`

## Requirements
- R1: While idle, a 0 on `cmd_in` is ignored. A 1 starts a command, and the next two ticks complete it. The second and third bits then decode as follows: 00 is a trigger, 10 is a bunch reset, 01 is an event reset, and 11 is both resets. Bits inside a command never start a new command. A new start bit is accepted on the tick that follows the third bit.
- R2: `bc_count` advances by one on every tick. On the tick after it equals `cfg_rollover`, it becomes 0, so one orbit is `cfg_rollover`+1 counts.
- R3: A bunch reset (code 110 or 111) loads `cfg_preset` on the clock edge that samples the third bit. That value appears on `bc_count` in the following cycle and replaces the normal increment or wrap.
- R4: A trigger sets `trig_valid` high for exactly one cycle, namely the cycle after the edge that samples its third bit. In that cycle, `trig_bcid` and `trig_evid` hold the `bc_count` and `ev_count` values from the tick of the third bit.
- R5: `ev_count` advances by one for each trigger. It clears to 0 on an event reset (101 or 111). A bunch-only reset (110) leaves it unchanged.
- R6: `coarse_time` equals (`bc_count`+`cfg_coarse_ofs`) mod (`cfg_rollover`+1). `reject_count` is formed the same way from `cfg_reject_ofs`. Both hold for offsets below twice the orbit length.
- R7: The earliest trigger sent right after a bunch reset receives the bunch number `cfg_preset`+2 mod orbit. With a preset of 0, the earliest number is 2. With preset 3552 and rollover 3563, the number 1 is reachable.
- R8: Asserting `rst_n` low clears both counters and `trig_valid` at once. After release, counting starts on the third rising edge, so `bc_count` reads 1 after three edges.
- R9: A preset as low as (`cfg_rollover`+1)-15 works. This corresponds to a reset advance of 15 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per bunch crossing |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 1 | Serial command line |
| cfg_rollover | input | 12 | Last count of an orbit |
| cfg_preset | input | 12 | Value loaded on a bunch reset |
| cfg_coarse_ofs | input | 12 | Offset added to form coarse time |
| cfg_reject_ofs | input | 12 | Offset added to form reject count |
| trig_valid | output | 1 | One-cycle trigger pulse |
| trig_bcid | output | 12 | Bunch number stamped on the last trigger |
| trig_evid | output | 12 | Event number stamped on the last trigger |
| bc_count | output | 12 | Live bunch crossing count |
| ev_count | output | 12 | Live event count |
| coarse_time | output | 12 | Bunch count plus coarse offset, wrapped |
| reject_count | output | 12 | Bunch count plus reject offset, wrapped |

## Verification
Results have fixed latencies. A command's effect is due one cycle after the edge that samples its third bit: the trigger pulse and its stamps, the preset load, and the event count change. `coarse_time` and `reject_count` follow `bc_count` combinationally, in the same cycle. The bench drives each bit on a falling edge. It then samples on the falling edge right after the third bit, so every expected value is the count at the third bit plus exactly one tick. Expected bunch numbers come from the preset plus the idle gap plus two, reduced modulo the orbit.

// File: rtl/bxc_pkg.sv
package bxc_pkg;

  localparam int BC_W  = 12;
  localparam int EV_W  = 12;
  localparam int CFG_W = 12;

  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_BIT1 = 2'd1,
    DEC_BIT2 = 2'd2
  } dec_state_e;

  typedef struct packed {
    logic trig;
    logic bcr;
    logic ecr;
  } cmd_strobe_t;

endpackage

// File: rtl/bxc_rst_sync.sv
module bxc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bxc_cmd_decoder.sv
module bxc_cmd_decoder
  import bxc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_i,
  output cmd_strobe_t strobe_o
);

  dec_state_e state_q, state_d;
  logic       mid_q, mid_d;

  always_comb begin
    state_d  = state_q;
    mid_d    = mid_q;
    strobe_o = '0;
    unique case (state_q)
      DEC_IDLE: begin
        if (cmd_i) begin
          state_d = DEC_BIT1;
        end
      end
      DEC_BIT1: begin
        mid_d   = cmd_i;
        state_d = DEC_BIT2;
      end
      DEC_BIT2: begin
        strobe_o.trig = !mid_q && !cmd_i;
        strobe_o.bcr  = mid_q;
        strobe_o.ecr  = cmd_i;
        state_d       = DEC_IDLE;
      end
      default: begin
        state_d = DEC_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DEC_IDLE;
      mid_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mid_q   <= mid_d;
    end
  end

  // R1: a decoded command always traces back to a start bit two ticks earlier
  assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe_o) |-> $past(cmd_i, 2));

  // R1: two commands are never decoded on adjacent ticks
  assert_cmd_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe_o) |=> !(|strobe_o));

endmodule

// File: rtl/bxc_bunch_counter.sv
module bxc_bunch_counter #(
  parameter int W = bxc_pkg::BC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bcr_i,
  input  logic [W-1:0] rollover_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] count_q, count_d;
  logic         at_end;

  always_comb begin
    at_end  = (count_q >= rollover_i);
    count_d = count_q + 1'b1;
    if (bcr_i) begin
      count_d = preset_i;
    end else if (at_end) begin
      count_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

  // R2: the tick after the last count of an orbit reads zero
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bcr_i && count_q == rollover_i) |=> (count_q == '0));

  // R3: a bunch reset loads the preset seen on the same tick
  assert_preset_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bcr_i |=> (count_q == $past(preset_i)));

endmodule

// File: rtl/bxc_event_counter.sv
module bxc_event_counter #(
  parameter int W = bxc_pkg::EV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig_i,
  input  logic         ecr_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] count_q, count_d;
  logic         cnt_en;

  always_comb begin
    cnt_en  = trig_i || ecr_i;
    count_d = count_q;
    if (ecr_i) begin
      count_d = '0;
    end else if (trig_i) begin
      count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

  // R5: each trigger adds exactly one
  assert_evt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !ecr_i) |=> (count_q == W'($past(count_q) + 1'b1)));

  // R5: an event reset clears the count
  assert_evt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ecr_i |=> (count_q == '0));

  // R5: with no command the count holds
  assert_evt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !ecr_i) |=> $stable(count_q));

endmodule

// File: rtl/bxc_mod_add.sv
module bxc_mod_add #(
  parameter int W    = bxc_pkg::BC_W,
  parameter int NSUB = 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] rollover_i,
  output logic [W-1:0] sum_o
);

  localparam int SW = W + 1;

  logic [SW-1:0]           modulus;
  logic [NSUB:0][SW-1:0]   stage;

  always_comb begin
    modulus  = {1'b0, rollover_i} + 1'b1;
    stage[0] = {1'b0, a_i} + {1'b0, b_i};
  end

  for (genvar gi = 0; gi < NSUB; gi++) begin : g_reduce
    assign stage[gi+1] = (stage[gi] >= modulus) ? (stage[gi] - modulus)
                                                : stage[gi];
  end

  assign sum_o = stage[NSUB][W-1:0];

endmodule

// File: rtl/bxc_timing_core.sv
module bxc_timing_core
  import bxc_pkg::*;
#(
  parameter int BCW      = BC_W,
  parameter int EVW      = EV_W,
  parameter int SYNC_LEN = 2,
  parameter int NSUB     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_in,
  input  logic [BCW-1:0] cfg_rollover,
  input  logic [BCW-1:0] cfg_preset,
  input  logic [BCW-1:0] cfg_coarse_ofs,
  input  logic [BCW-1:0] cfg_reject_ofs,
  output logic           trig_valid,
  output logic [BCW-1:0] trig_bcid,
  output logic [EVW-1:0] trig_evid,
  output logic [BCW-1:0] bc_count,
  output logic [EVW-1:0] ev_count,
  output logic [BCW-1:0] coarse_time,
  output logic [BCW-1:0] reject_count
);

  localparam int NOFS = 2;

  logic        rst_core_n;
  cmd_strobe_t strobe;

  logic [NOFS-1:0][BCW-1:0] ofs_in;
  logic [NOFS-1:0][BCW-1:0] ofs_out;

  logic           tv_q, tv_d;
  logic [BCW-1:0] tb_q, tb_d;
  logic [EVW-1:0] te_q, te_d;

  bxc_rst_sync #(.STAGES(SYNC_LEN)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  bxc_cmd_decoder u_decoder (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cmd_i    (cmd_in),
    .strobe_o (strobe)
  );

  bxc_bunch_counter #(.W(BCW)) u_bunch (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bcr_i      (strobe.bcr),
    .rollover_i (cfg_rollover),
    .preset_i   (cfg_preset),
    .count_o    (bc_count)
  );

  bxc_event_counter #(.W(EVW)) u_event (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .trig_i  (strobe.trig),
    .ecr_i   (strobe.ecr),
    .count_o (ev_count)
  );

  assign ofs_in[0] = cfg_coarse_ofs;
  assign ofs_in[1] = cfg_reject_ofs;

  for (genvar gi = 0; gi < NOFS; gi++) begin : g_ofs
    bxc_mod_add #(.W(BCW), .NSUB(NSUB)) u_add (
      .a_i        (bc_count),
      .b_i        (ofs_in[gi]),
      .rollover_i (cfg_rollover),
      .sum_o      (ofs_out[gi])
    );
  end

  assign coarse_time  = ofs_out[0];
  assign reject_count = ofs_out[1];

  // trigger stamp: next-state
  always_comb begin
    tv_d = strobe.trig;
    tb_d = tb_q;
    te_d = te_q;
    if (strobe.trig) begin
      tb_d = bc_count;
      te_d = ev_count;
    end
  end

  // trigger stamp: registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tv_q <= 1'b0;
      tb_q <= '0;
      te_q <= '0;
    end else begin
      tv_q <= tv_d;
      tb_q <= tb_d;
      te_q <= te_d;
    end
  end

  assign trig_valid = tv_q;
  assign trig_bcid  = tb_q;
  assign trig_evid  = te_q;

  // R4: the trigger pulse lasts one cycle
  assert_trig_single_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    trig_valid |=> !trig_valid);

  // R4: the stamped bunch number is the count on the completing tick
  assert_trig_stamp_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    trig_valid |-> (trig_bcid == $past(bc_count)));

  // R5: right after a trigger the live count is one past its stamp
  assert_evid_follow_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    trig_valid |-> (ev_count == EVW'(trig_evid + 1'b1)));

  // R6: derived outputs stay inside the orbit
  assert_coarse_range_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((bc_count <= cfg_rollover) &&
     ({1'b0, cfg_coarse_ofs} <= {cfg_rollover, 1'b1}))
    |-> (coarse_time <= cfg_rollover));

  assert_reject_range_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((bc_count <= cfg_rollover) &&
     ({1'b0, cfg_reject_ofs} <= {cfg_rollover, 1'b1}))
    |-> (reject_count <= cfg_rollover));

endmodule

// File: tb/test_bxc_timing_core.sv
`timescale 1ns/1ps
module test_bxc_timing_core;

  logic        clk;
  logic        rst_n;
  logic        cmd_in;
  logic [11:0] cfg_rollover, cfg_preset, cfg_coarse_ofs, cfg_reject_ofs;
  logic        trig_valid;
  logic [11:0] trig_bcid, trig_evid, bc_count, ev_count, coarse_time, reject_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  bxc_timing_core i_bxc_timing_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_in         (cmd_in),
    .cfg_rollover   (cfg_rollover),
    .cfg_preset     (cfg_preset),
    .cfg_coarse_ofs (cfg_coarse_ofs),
    .cfg_reject_ofs (cfg_reject_ofs),
    .trig_valid     (trig_valid),
    .trig_bcid      (trig_bcid),
    .trig_evid      (trig_evid),
    .bc_count       (bc_count),
    .ev_count       (ev_count),
    .coarse_time    (coarse_time),
    .reject_count   (reject_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // fields: rollover, preset, coarse offset, reject offset, idle gap
  localparam int NVEC = 7;
  localparam logic [59:0] VEC [NVEC] = '{
    {12'd3563, 12'd3552, 12'h079, 12'hDBF, 12'd10},
    {12'd3563, 12'd3552, 12'h079, 12'hDBF, 12'd11},
    {12'd3563, 12'd0,    12'h084, 12'hFDE, 12'd0},
    {12'd3563, 12'd3549, 12'h079, 12'hDBF, 12'd0},
    {12'd15,   12'd13,   12'd20,  12'd30,  12'd5},
    {12'd3563, 12'd3552, 12'h079, 12'hDBF, 12'd300},
    {12'd3563, 12'd0,    12'h084, 12'hFDE, 12'd3600}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [2:0] code);
    for (int k = 2; k >= 0; k--) begin
      cmd_in = code[k];
      @(negedge clk);
    end
    cmd_in = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rl, pr, oc, orj, gap, m, eb, ebc, ev0, b1;
    rst_n = 1'b0;
    cmd_in = 1'b0;
    cfg_rollover = 12'd3563;
    cfg_preset = 12'd3552;
    cfg_coarse_ofs = 12'h079;
    cfg_reject_ofs = 12'hDBF;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 bc in reset", bc_count, 0);
    check("R8 ev in reset", ev_count, 0);
    check("R8 trig in reset", trig_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 first count after release", bc_count, 1);

    // R1: idle zeros produce nothing
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (trig_valid) seen++;
      end
      check("R1 idle zeros ignored", seen, 0);
      check("R1 idle zeros keep ev", ev_count, 0);
    end

    // vector table: bunch reset, gap, trigger
    for (int v = 0; v < NVEC; v++) begin
      rl  = int'(VEC[v][59:48]);
      pr  = int'(VEC[v][47:36]);
      oc  = int'(VEC[v][35:24]);
      orj = int'(VEC[v][23:12]);
      gap = int'(VEC[v][11:0]);
      m   = rl + 1;
      cfg_rollover = 12'(rl);
      cfg_preset = 12'(pr);
      cfg_coarse_ofs = 12'(oc);
      cfg_reject_ofs = 12'(orj);
      send_cmd(3'b110);
      check("R3 preset loaded", bc_count, pr);
      repeat (gap) @(negedge clk);
      ev0 = ev_count;
      send_cmd(3'b100);
      eb  = (pr + 2 + gap) % m;
      ebc = (pr + 3 + gap) % m;
      check("R4 trigger pulse", trig_valid, 1);
      check("R7 stamped bunch number", trig_bcid, eb);
      check("R4 stamped event number", trig_evid, ev0);
      check("R2 live bunch count", bc_count, ebc);
      check("R6 coarse time", coarse_time, (ebc + oc) % m);
      check("R6 reject count", reject_count, (ebc + orj) % m);
      @(negedge clk);
      check("R4 pulse ends", trig_valid, 0);
    end

    // R9: largest advance stamps 3551 at gap 0 (vector 4); also legacy min is 2 (vector 3)
    cfg_rollover = 12'd3563;
    cfg_preset = 12'd3552;
    cfg_coarse_ofs = 12'h079;
    cfg_reject_ofs = 12'hDBF;

    // R5: event reset then triggers
    send_cmd(3'b101);
    check("R5 event reset clears", ev_count, 0);
    send_cmd(3'b100);
    check("R5 first evid after clear", trig_evid, 0);
    check("R5 count after trigger", ev_count, 1);
    b1 = trig_bcid;
    // R1: back-to-back triggers, new start bit right after third bit
    send_cmd(3'b100);
    check("R1 back-to-back trigger pulse", trig_valid, 1);
    check("R1 back-to-back bunch spacing", trig_bcid, (b1 + 3) % 3564);
    check("R5 second evid", trig_evid, 1);
    check("R5 count after two", ev_count, 2);
    // R5: bunch-only reset leaves events
    send_cmd(3'b110);
    check("R5 bunch reset keeps events", ev_count, 2);
    check("R3 bunch reset via 110", bc_count, 3552);
    // R3/R5: combined reset
    repeat (7) @(negedge clk);
    send_cmd(3'b111);
    check("R5 combined reset clears events", ev_count, 0);
    check("R3 combined reset loads preset", bc_count, 3552);
    // R1: ones inside a command do not start another one
    check("R1 no trigger from 111", trig_valid, 0);
    send_cmd(3'b100);
    check("R1 trigger after 111", trig_valid, 1);
    check("R1 trigger evid after 111", trig_evid, 0);

    // R8: asynchronous clear mid-run
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async clear bc", bc_count, 0);
    check("R8 async clear ev", ev_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 count restarts", bc_count, 1);

    finish_run();
  end

endmodule